// File: doc/BRIEF.md
# Row Reference Gain Corrector

This block takes a stream of digitized sensor pixels, one row after another. Every row carries a configurable number of active image pixels and then a short tail of masked reference pixels that received no light. Along the row, charge is lost as it is shifted toward the output amplifier. The reference tail shows how much signal was lost for that row. The block adds up the tail, derives a per-row gain that restores the reference level to a fixed target, and multiplies the row's active pixels by that gain.

The reference pixels come after the active pixels they describe. For this reason the active part of a row is kept in one half of a ping-pong buffer while the next row fills the other half. A row's corrected pixels leave the block while the following row is arriving. The reference tail is dropped from the output. Both edges use valid/ready handshakes, and output order matches input order.

Top module: `row_gain_corrector`

## Requirements
- R1: A row is `cfg_len` active pixels (1 to MAX_LEN) followed by reference pixels: five when `cfg_ref_six` is 0, six when it is 1. The output carries only the active pixels, in arrival order. `out_last` is high on the last active pixel of each row.
- R2: With S the sum of a row's reference pixels and N their count, the row gain is g = floor(TARGET·N·256 / S). This is unsigned fixed point with 8 fractional bits, and TARGET defaults to 2048.
- R3: The gain is clamped to the range 256 to 1280, which is 1.0 to 5.0.
- R4: A reference sum of zero gives the maximum gain of 1280.
- R5: Each corrected pixel equals min(4095, floor(p·g / 256)).
- R6: A row is corrected only with the gain from its own reference pixels, never with the gain of a neighbouring row.
- R7: While `out_ready` is low and `out_valid` is high, `out_valid`, `out_pixel` and `out_last` do not change.
- R8: `in_ready` goes low while both row buffers hold rows that have not been fully output. No pixel is lost or repeated under backpressure.
- R9: After reset, `out_valid` is 0 and `in_ready` is 1. A partly received row is discarded, and the next pixel accepted starts a new row.
- R10: `cfg_len` and `cfg_ref_six` are taken when a row's first pixel is accepted. Changes made later in that row do not affect it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_len | input | $clog2(MAX_LEN+1) | Active pixels per row |
| cfg_ref_six | input | 1 | 0: five reference pixels, 1: six |
| in_valid | input | 1 | Input pixel valid |
| in_ready | output | 1 | Input pixel accepted when high with in_valid |
| in_pixel | input | PIX_W | Input pixel value |
| out_valid | output | 1 | Corrected pixel valid |
| out_ready | input | 1 | Downstream accepts the corrected pixel |
| out_pixel | output | PIX_W | Corrected pixel |
| out_last | output | 1 | Last active pixel of the row |

## Verification
Two functions can be active in the same cycle: output of a corrected row can stall on `out_ready`, and the next rows can be loaded into the free buffer and have their gains computed. The bench provokes this by holding `out_ready` low while it sends two rows back to back. It then checks that `in_ready` falls once both buffers are occupied and that the stalled output word stays stable. After `out_ready` is released, every pixel of both rows must drain in order with its own row's gain. A throttled `out_ready` pattern during the table rows also makes input and output transfers land in the same cycles.

// File: rtl/row_gain_pkg.sv
package row_gain_pkg;
  // Gain format: unsigned, FRAC_W fractional bits
  localparam int FRAC_W = 8;
  localparam int GAIN_W = 11;
  localparam logic [GAIN_W-1:0] GAIN_ONE = 11'd256;   // 1.0
  localparam logic [GAIN_W-1:0] GAIN_CAP = 11'd1280;  // 5.0
  localparam int REF_FEW  = 5;
  localparam int REF_MANY = 6;
  localparam int BANKS    = 2;
endpackage

// File: rtl/row_gain_ram.sv
module row_gain_ram #(
  parameter int DATA_W = 12,
  parameter int DEPTH  = 128,
  parameter int ADDR_W = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              we,
  input  logic [ADDR_W-1:0] waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic              re,
  input  logic [ADDR_W-1:0] raddr,
  output logic [DATA_W-1:0] rdata
);
  logic [DATA_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  always_ff @(posedge clk) begin
    if (re) rdata <= mem[raddr];
  end
endmodule

// File: rtl/row_gain_div.sv
module row_gain_div #(
  parameter int NUM_W = 23,
  parameter int DEN_W = 15
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic [NUM_W-1:0] num,
  input  logic [DEN_W-1:0] den,
  output logic             done,
  output logic [NUM_W-1:0] quo
);
  localparam int CNT_W = $clog2(NUM_W + 1);

  logic [DEN_W:0]   rem_q;
  logic [DEN_W-1:0] den_q;
  logic [CNT_W-1:0] cnt_q;
  logic             run_q;
  logic [DEN_W:0]   rem_sh;
  logic             fits;

  // One quotient bit per cycle, restoring form. A zero divisor
  // yields an all-ones quotient, which the caller clamps.
  assign rem_sh = {rem_q[DEN_W-1:0], quo[NUM_W-1]};
  assign fits   = rem_sh >= {1'b0, den_q};

  always_ff @(posedge clk) begin
    if (rst) begin
      rem_q <= '0;
      den_q <= '0;
      cnt_q <= '0;
      run_q <= 1'b0;
      done  <= 1'b0;
      quo   <= '0;
    end else begin
      done <= 1'b0;
      if (start) begin
        run_q <= 1'b1;
        quo   <= num;
        rem_q <= '0;
        den_q <= den;
        cnt_q <= CNT_W'(NUM_W);
      end else if (run_q) begin
        rem_q <= fits ? (rem_sh - {1'b0, den_q}) : rem_sh;
        quo   <= {quo[NUM_W-2:0], fits};
        cnt_q <= cnt_q - 1'b1;
        if (cnt_q == CNT_W'(1)) begin
          run_q <= 1'b0;
          done  <= 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/row_gain_wr.sv
module row_gain_wr #(
  parameter int PIX_W   = 12,
  parameter int MAX_LEN = 64,
  parameter int LEN_W   = $clog2(MAX_LEN + 1),
  parameter int ADDR_W  = $clog2(MAX_LEN),
  parameter int SUM_W   = PIX_W + 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [LEN_W-1:0]  cfg_len,
  input  logic              cfg_ref_six,
  input  logic              in_valid,
  input  logic [PIX_W-1:0]  in_pixel,
  input  logic [1:0]        bank_full,
  output logic              in_ready,
  output logic              we,
  output logic [ADDR_W:0]   waddr,
  output logic [PIX_W-1:0]  wdata,
  output logic              row_done,
  output logic              row_bank,
  output logic [SUM_W-1:0]  row_sum,
  output logic [LEN_W-1:0]  row_len,
  output logic              row_six
);
  localparam int CW = LEN_W + 1;

  logic [CW-1:0]    col_q;
  logic [LEN_W-1:0] len_q;
  logic             six_q;
  logic             bank_q;
  logic [SUM_W-1:0] sum_q;

  logic [LEN_W-1:0] eff_len;
  logic             eff_six;
  logic [CW-1:0]    last_col;
  logic             take;
  logic             is_ref;

  // Configuration counts from the first pixel of a row onward
  assign eff_len  = (col_q == '0) ? cfg_len : len_q;
  assign eff_six  = (col_q == '0) ? cfg_ref_six : six_q;
  assign last_col = CW'(eff_len) + (eff_six ? CW'(row_gain_pkg::REF_MANY)
                                            : CW'(row_gain_pkg::REF_FEW)) - CW'(1);
  assign in_ready = !bank_full[bank_q];
  assign take     = in_valid && in_ready;
  assign is_ref   = col_q >= CW'(eff_len);

  assign we    = take && !is_ref;
  assign waddr = {bank_q, col_q[ADDR_W-1:0]};
  assign wdata = in_pixel;

  always_ff @(posedge clk) begin
    if (rst) begin
      col_q    <= '0;
      len_q    <= '0;
      six_q    <= 1'b0;
      bank_q   <= 1'b0;
      sum_q    <= '0;
      row_done <= 1'b0;
      row_bank <= 1'b0;
      row_sum  <= '0;
      row_len  <= '0;
      row_six  <= 1'b0;
    end else begin
      row_done <= 1'b0;
      if (take) begin
        if (col_q == '0) begin
          len_q <= cfg_len;
          six_q <= cfg_ref_six;
        end
        if (col_q == last_col) begin
          row_done <= 1'b1;
          row_bank <= bank_q;
          row_sum  <= sum_q + SUM_W'(in_pixel);
          row_len  <= eff_len;
          row_six  <= eff_six;
          col_q    <= '0;
          sum_q    <= '0;
          bank_q   <= ~bank_q;
        end else begin
          col_q <= col_q + CW'(1);
          if (is_ref) sum_q <= sum_q + SUM_W'(in_pixel);
        end
      end
    end
  end
endmodule

// File: rtl/row_gain_rd.sv
module row_gain_rd #(
  parameter int PIX_W   = 12,
  parameter int MAX_LEN = 64,
  parameter int LEN_W   = $clog2(MAX_LEN + 1),
  parameter int ADDR_W  = $clog2(MAX_LEN),
  parameter int GAIN_W  = row_gain_pkg::GAIN_W
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic [1:0]             bank_ok,
  input  logic [1:0][GAIN_W-1:0] bank_gain,
  input  logic [1:0][LEN_W-1:0]  bank_len,
  input  logic [PIX_W-1:0]       ram_q,
  input  logic                   out_ready,
  output logic                   rd_en,
  output logic [ADDR_W:0]        raddr,
  output logic                   rel,
  output logic                   rel_bank,
  output logic                   out_valid,
  output logic [PIX_W-1:0]       out_pixel,
  output logic                   out_last
);
  localparam int FRAC_W = row_gain_pkg::FRAC_W;
  localparam int PROD_W = PIX_W + GAIN_W;
  localparam int SCL_W  = PROD_W - FRAC_W;

  logic [LEN_W-1:0]  col_q;
  logic              bank_q;
  logic              va_q;
  logic              last_a_q;
  logic [GAIN_W-1:0] g_a_q;
  logic              adv;
  logic              at_end;
  logic [PROD_W-1:0] prod;
  logic [SCL_W-1:0]  scaled;
  logic [PIX_W-1:0]  sat_pix;

  assign adv      = !out_valid || out_ready;
  assign rd_en    = adv && bank_ok[bank_q];
  assign at_end   = col_q == (bank_len[bank_q] - LEN_W'(1));
  assign raddr    = {bank_q, col_q[ADDR_W-1:0]};
  assign rel      = rd_en && at_end;
  assign rel_bank = bank_q;

  assign prod    = PROD_W'(ram_q) * PROD_W'(g_a_q);
  assign scaled  = prod[PROD_W-1:FRAC_W];
  assign sat_pix = (|scaled[SCL_W-1:PIX_W]) ? '1 : scaled[PIX_W-1:0];

  always_ff @(posedge clk) begin
    if (rst) begin
      col_q     <= '0;
      bank_q    <= 1'b0;
      va_q      <= 1'b0;
      last_a_q  <= 1'b0;
      g_a_q     <= row_gain_pkg::GAIN_ONE;
      out_valid <= 1'b0;
      out_pixel <= '0;
      out_last  <= 1'b0;
    end else if (adv) begin
      va_q      <= rd_en;
      last_a_q  <= rd_en && at_end;
      g_a_q     <= bank_gain[bank_q];
      out_valid <= va_q;
      out_pixel <= sat_pix;
      out_last  <= last_a_q;
      if (rd_en) begin
        if (at_end) begin
          col_q  <= '0;
          bank_q <= ~bank_q;
        end else begin
          col_q <= col_q + LEN_W'(1);
        end
      end
    end
  end
endmodule

// File: rtl/row_gain_corrector.sv
module row_gain_corrector #(
  parameter int PIX_W   = 12,
  parameter int MAX_LEN = 64,
  parameter int TARGET  = 2048,
  parameter int LEN_W   = $clog2(MAX_LEN + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [LEN_W-1:0] cfg_len,
  input  logic             cfg_ref_six,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic [PIX_W-1:0] in_pixel,
  output logic             out_valid,
  input  logic             out_ready,
  output logic [PIX_W-1:0] out_pixel,
  output logic             out_last
);
  import row_gain_pkg::*;

  localparam int ADDR_W = $clog2(MAX_LEN);
  localparam int SUM_W  = PIX_W + 3;
  localparam int NUM_W  = PIX_W + 3 + FRAC_W;

  logic                   we;
  logic [ADDR_W:0]        waddr;
  logic [PIX_W-1:0]       wdata;
  logic                   rd_en;
  logic [ADDR_W:0]        raddr;
  logic [PIX_W-1:0]       ram_q;
  logic                   wr_done;
  logic                   wr_bank;
  logic [SUM_W-1:0]       wr_sum;
  logic [LEN_W-1:0]       wr_len;
  logic                   wr_six;
  logic                   rel;
  logic                   rel_bank;
  logic [NUM_W-1:0]       num;

  logic [1:0]             full_q;
  logic [1:0]             gready_q;
  logic [1:0][GAIN_W-1:0] gain_q;
  logic [1:0][LEN_W-1:0]  blen_q;
  logic [1:0]             div_done;
  logic [1:0][NUM_W-1:0]  div_quo;

  function automatic logic [GAIN_W-1:0] clamp_gain(input logic [NUM_W-1:0] q);
    if (q > NUM_W'(GAIN_CAP))      return GAIN_CAP;
    else if (q < NUM_W'(GAIN_ONE)) return GAIN_ONE;
    else                           return q[GAIN_W-1:0];
  endfunction

  row_gain_wr #(
    .PIX_W(PIX_W), .MAX_LEN(MAX_LEN), .LEN_W(LEN_W),
    .ADDR_W(ADDR_W), .SUM_W(SUM_W)
  ) i_wr (
    .clk(clk), .rst(rst), .cfg_len(cfg_len), .cfg_ref_six(cfg_ref_six),
    .in_valid(in_valid), .in_pixel(in_pixel), .bank_full(full_q),
    .in_ready(in_ready), .we(we), .waddr(waddr), .wdata(wdata),
    .row_done(wr_done), .row_bank(wr_bank), .row_sum(wr_sum),
    .row_len(wr_len), .row_six(wr_six)
  );

  row_gain_ram #(
    .DATA_W(PIX_W), .DEPTH(BANKS * (1 << ADDR_W)), .ADDR_W(ADDR_W + 1)
  ) i_ram (
    .clk(clk), .we(we), .waddr(waddr), .wdata(wdata),
    .re(rd_en), .raddr(raddr), .rdata(ram_q)
  );

  // Numerator: TARGET * N, in gain fixed point
  assign num = (NUM_W'(TARGET) * (wr_six ? NUM_W'(REF_MANY) : NUM_W'(REF_FEW))) << FRAC_W;

  for (genvar b = 0; b < BANKS; b++) begin : g_bank
    row_gain_div #(.NUM_W(NUM_W), .DEN_W(SUM_W)) i_div (
      .clk(clk), .rst(rst),
      .start(wr_done && (wr_bank == 1'(b))),
      .num(num), .den(wr_sum),
      .done(div_done[b]), .quo(div_quo[b])
    );
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      full_q   <= '0;
      gready_q <= '0;
      gain_q   <= {BANKS{GAIN_ONE}};
      blen_q   <= '0;
    end else begin
      for (int b = 0; b < BANKS; b++) begin
        if (rel && (rel_bank == 1'(b))) begin
          full_q[b]   <= 1'b0;
          gready_q[b] <= 1'b0;
        end else begin
          if (wr_done && (wr_bank == 1'(b))) begin
            full_q[b] <= 1'b1;
            blen_q[b] <= wr_len;
          end
          if (div_done[b]) begin
            gready_q[b] <= 1'b1;
            gain_q[b]   <= clamp_gain(div_quo[b]);
          end
        end
      end
    end
  end

  row_gain_rd #(
    .PIX_W(PIX_W), .MAX_LEN(MAX_LEN), .LEN_W(LEN_W),
    .ADDR_W(ADDR_W), .GAIN_W(GAIN_W)
  ) i_rd (
    .clk(clk), .rst(rst), .bank_ok(full_q & gready_q),
    .bank_gain(gain_q), .bank_len(blen_q), .ram_q(ram_q),
    .out_ready(out_ready), .rd_en(rd_en), .raddr(raddr),
    .rel(rel), .rel_bank(rel_bank), .out_valid(out_valid),
    .out_pixel(out_pixel), .out_last(out_last)
  );
endmodule

// File: rtl/row_gain_chk.sv
module row_gain_chk #(
  parameter int PIX_W  = 12,
  parameter int GAIN_W = 11
) (
  input logic                   clk,
  input logic                   rst,
  input logic                   in_ready,
  input logic                   out_valid,
  input logic                   out_ready,
  input logic [PIX_W-1:0]       out_pixel,
  input logic                   out_last,
  input logic [1:0]             bank_full,
  input logic [1:0]             bank_gready,
  input logic [1:0][GAIN_W-1:0] bank_gain
);
  AST_OUT_HOLD: assert property (@(posedge clk) disable iff (rst)
    out_valid && !out_ready |=> out_valid && $stable(out_pixel) && $stable(out_last)); // R7
  AST_BOTH_FULL_STALL: assert property (@(posedge clk) disable iff (rst)
    (&bank_full) |-> !in_ready); // R8
  AST_GAIN_RANGE_B0: assert property (@(posedge clk) disable iff (rst)
    bank_gready[0] |-> (bank_gain[0] >= 11'd256) && (bank_gain[0] <= 11'd1280)); // R3
  AST_GAIN_RANGE_B1: assert property (@(posedge clk) disable iff (rst)
    bank_gready[1] |-> (bank_gain[1] >= 11'd256) && (bank_gain[1] <= 11'd1280)); // R3
  AST_GAIN_OWN_ROW_B0: assert property (@(posedge clk) disable iff (rst)
    bank_gready[0] |-> bank_full[0]); // R6
  AST_GAIN_OWN_ROW_B1: assert property (@(posedge clk) disable iff (rst)
    bank_gready[1] |-> bank_full[1]); // R6
endmodule

bind row_gain_corrector row_gain_chk #(
  .PIX_W(PIX_W), .GAIN_W(row_gain_pkg::GAIN_W)
) i_chk (
  .clk(clk), .rst(rst), .in_ready(in_ready), .out_valid(out_valid),
  .out_ready(out_ready), .out_pixel(out_pixel), .out_last(out_last),
  .bank_full(full_q), .bank_gready(gready_q), .bank_gain(gain_q)
);

// File: tb/test_row_gain_corrector.sv
`timescale 1ns/1ps
module test_row_gain_corrector;
  localparam int PIX_W   = 12;
  localparam int MAX_LEN = 64;
  localparam int LEN_W   = $clog2(MAX_LEN + 1);
  localparam int TARGET  = 2048;
  localparam int ROWS    = 8;
  // len, six refs, ref base, ref step, pixel seed
  localparam int TAB [ROWS][5] = '{
    '{ 8, 0, 2048, 1,  100},   // R3 lower clamp
    '{ 8, 1, 1024, 2,  500},   // R2 plain gain
    '{ 5, 0,  300, 1, 4000},   // R3 upper clamp, R5 saturation
    '{12, 0,    0, 0,   77},   // R4 zero references
    '{10, 1, 2048, 0, 3000},   // R1 six references, unity gain
    '{ 1, 0, 1500, 4, 2222},   // R1 single pixel row
    '{64, 1,  900, 5,    9},   // R1 maximum length
    '{ 7, 0,  800, 3, 1234}    // R6 gain differs from previous rows
  };

  logic             clk = 1'b0;
  logic             rst;
  logic [LEN_W-1:0] cfg_len;
  logic             cfg_ref_six;
  logic             in_valid;
  logic             in_ready;
  logic [PIX_W-1:0] in_pixel;
  logic             out_valid;
  logic             out_ready = 1'b0;
  logic [PIX_W-1:0] out_pixel;
  logic             out_last;

  int    checks = 0;
  int    fails  = 0;
  int    ready_mode = 0;
  int    cyc = 0;
  int    exp_pix[$];
  bit    exp_last[$];
  string exp_tag[$];

  row_gain_corrector #(.PIX_W(PIX_W), .MAX_LEN(MAX_LEN), .TARGET(TARGET)) i_row_gain_corrector (
    .clk(clk), .rst(rst), .cfg_len(cfg_len), .cfg_ref_six(cfg_ref_six),
    .in_valid(in_valid), .in_ready(in_ready), .in_pixel(in_pixel),
    .out_valid(out_valid), .out_ready(out_ready), .out_pixel(out_pixel),
    .out_last(out_last)
  );

  always #2.5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  function automatic string tag_of(input int i);
    case (i)
      0: return "R3";
      1: return "R2";
      2: return "R5";
      3: return "R4";
      4: return "R1";
      5: return "R1";
      6: return "R1";
      default: return "R6";
    endcase
  endfunction

  function automatic int exp_gain(input int s, input int n);
    int q;
    if (s == 0) return 1280;
    q = (TARGET * n * 256) / s;
    if (q > 1280) q = 1280;
    if (q < 256) q = 256;
    return q;
  endfunction

  function automatic int pix_of(input int seed, input int i);
    return (seed + i * 613) % 4096;
  endfunction

  task automatic check(input bit ok, input string tag, input string what,
                       input int act, input int expv);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, expv);
    end
  endtask

  // Output side: ready pattern and comparison against the expected queue
  always @(negedge clk) begin
    case (ready_mode)
      0:       out_ready = 1'b1;
      1:       out_ready = (cyc % 3) != 1;
      default: out_ready = 1'b0;
    endcase
    if (!rst && out_valid && out_ready) begin
      if (exp_pix.size() == 0) begin
        check(1'b0, "R1", "unexpected output pixel", int'(out_pixel), -1);
      end else begin
        check(int'(out_pixel) == exp_pix[0], exp_tag[0], "pixel", int'(out_pixel), exp_pix[0]);
        check(out_last == exp_last[0], "R1", "out_last", int'(out_last), int'(exp_last[0]));
        void'(exp_pix.pop_front());
        void'(exp_last.pop_front());
        void'(exp_tag.pop_front());
      end
    end
  end

  task automatic set_mode(input int m);
    @(posedge clk);
    ready_mode = m;
    @(negedge clk);
  endtask

  // Called at a falling edge; returns at the falling edge after acceptance
  task automatic send_px(input int p);
    bit acc;
    in_valid = 1'b1;
    in_pixel = PIX_W'(p);
    while (1) begin
      acc = in_ready;
      @(negedge clk);
      if (acc) break;
    end
  endtask

  task automatic send_row(input int len, input int six, input int refv, input int step,
                          input int seed, input string tag, input bit alt);
    int n;
    int s;
    int g;
    int v;
    n = (six != 0) ? 6 : 5;
    s = 0;
    for (int j = 0; j < n; j++) s += refv + j * step;
    g = exp_gain(s, n);
    for (int i = 0; i < len; i++) begin
      v = (pix_of(seed, i) * g) / 256;
      if (v > 4095) v = 4095;
      exp_pix.push_back(v);
      exp_last.push_back(i == len - 1);
      exp_tag.push_back(tag);
    end
    cfg_len     = LEN_W'(len);
    cfg_ref_six = (six != 0);
    for (int i = 0; i < len; i++) begin
      send_px(pix_of(seed, i));
      if (alt && i == 0) begin
        cfg_len     = LEN_W'(len + 4);
        cfg_ref_six = (six == 0);
      end
    end
    for (int j = 0; j < n; j++) send_px(refv + j * step);
    in_valid = 1'b0;
  endtask

  task automatic drain(input string tag);
    int t;
    t = 0;
    while (exp_pix.size() != 0 && t < 3000) begin
      @(negedge clk);
      t++;
    end
    check(exp_pix.size() == 0, tag, "pixels left undelivered", exp_pix.size(), 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog expired: actual %0d cycles expected fewer", cyc);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    int held;
    rst = 1'b1;
    in_valid = 1'b0;
    in_pixel = '0;
    cfg_len = LEN_W'(8);
    cfg_ref_six = 1'b0;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R9: reset state
    check(out_valid == 1'b0, "R9", "out_valid after reset", int'(out_valid), 0);
    check(in_ready == 1'b1, "R9", "in_ready after reset", int'(in_ready), 1);

    // Table rows under a throttled output
    set_mode(1);
    for (int r = 0; r < ROWS; r++)
      send_row(TAB[r][0], TAB[r][1], TAB[r][2], TAB[r][3], TAB[r][4], tag_of(r), 1'b0);
    drain("R1");

    // R8 / R7: two rows fill both buffers while the output is stalled
    set_mode(2);
    send_row(4, 0, 1000, 1, 50, "R8", 1'b0);
    send_row(4, 0, 600, 2, 60, "R8", 1'b0);
    repeat (40) @(negedge clk);
    check(in_ready == 1'b0, "R8", "in_ready with both buffers held", int'(in_ready), 0);
    check(out_valid == 1'b1, "R7", "out_valid while stalled", int'(out_valid), 1);
    held = int'(out_pixel);
    repeat (5) @(negedge clk);
    check(out_valid == 1'b1, "R7", "out_valid held", int'(out_valid), 1);
    check(int'(out_pixel) == held, "R7", "out_pixel held", int'(out_pixel), held);
    set_mode(0);
    drain("R8");

    // R10: configuration changed after the first pixel of a row
    send_row(6, 0, 1200, 2, 321, "R10", 1'b1);
    drain("R10");

    // R9: reset in the middle of a row discards it
    cfg_len = LEN_W'(8);
    cfg_ref_six = 1'b0;
    for (int i = 0; i < 3; i++) send_px(4000);
    in_valid = 1'b0;
    rst = 1'b1;
    repeat (2) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check(in_ready == 1'b1, "R9", "in_ready after mid-row reset", int'(in_ready), 1);
    check(out_valid == 1'b0, "R9", "out_valid after mid-row reset", int'(out_valid), 0);
    send_row(8, 1, 1600, 1, 888, "R9", 1'b0);
    drain("R9");

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule